// File: doc/BRIEF.md
# Subset-Indexed Decision State Sequencer

This block is a state machine whose behaviour lives entirely in a small word memory rather than in logic. The current state addresses one word. The word names one subset of exactly `K_SEL` distinct inputs, taken from the `N_IN` inputs of the machine. It also holds `2^K_SEL` next-state pointers and an output pattern. On each clock the selected input bits pick one of the pointers, and that pointer becomes the new state. The output pattern follows the current state (Moore form).

A subset is named by one packed index of `ceil(log2 C(N_IN,K_SEL))` bits. Per-bit selectors would take `K_SEL*ceil(log2 N_IN)` bits, so the packed index keeps the memory word as narrow as it can be. A combinational decoder turns the index into `K_SEL` input positions. The decoder is built at elaboration from the parameters.

The memory is loaded through a write port that only acts while the sequencer is held in reset. With the defaults (4 inputs, 2 tested per step, 8 states, 4 output bits) a word is 3 + 4·3 + 4 = 19 bits.

Top module: `fsm_seq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces the state to 0, and the state stays 0 while `rst` remains high.
- R2: The word layout has three fields. The subset index is in bits [SEL_W-1:0]. Next-state field j is in bits [SEL_W+j·STATE_W +: STATE_W]. The output field is in the top OUT_W bits. With the defaults this is: index in [2:0], field j in [3+3j +: 3], output in [18:15].
- R3: Subsets are ranked in lexicographic order of their ascending input positions. For 4 inputs and 2 tested bits, ranks 0 to 5 are {0,1}, {0,2}, {0,3}, {1,2}, {1,3}, {2,3}. The lowest input position of the subset supplies the least significant bit of the field select.
- R4: When out of reset, every rising edge loads the state with the next-state field chosen by the tested bits. This is one full transition per clock.
- R5: `outVec` equals the output field of the word addressed by the current state, in the same cycle.
- R6: A subset index of C(N_IN,K_SEL) or more is illegal. For such an index `selErr` is high and the next state comes from field 0. For a legal index `selErr` is low.
- R7: A write (`wrEn` high) changes the memory only while `rst` is high. A write out of reset has no effect on any later output or transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables loading |
| wrEn | input | 1 | Memory write strobe (acts only in reset) |
| wrAddr | input | STATE_W | Word address for a write |
| wrData | input | WORD_W | Word to write (layout per R2) |
| inVec | input | N_IN | Input variables tested by the machine |
| stateOut | output | STATE_W | Current state register |
| outVec | output | OUT_W | Output field of the current word |
| selErr | output | 1 | High when the current word holds an illegal subset index |

## Verification
`outVec` and `selErr` are combinational from the state register and the memory, so they are due in the same cycle as the state they belong to. The bench reads them before it drives the next inputs. A new state appears one rising edge after the inputs that select it, and a write made in reset is visible in the cycle after its edge. Every check samples 1 ns after a rising edge, when those registers have settled, and inputs change only at that same point.

// File: rtl/fsm_seq_pkg.sv
package fsm_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;    // memory write allowed
    logic clrState;  // force state to zero
    logic stepEn;    // take a transition
  } seqStrobe_t;

  function automatic int binom(input int a, input int b);
    int res;
    if (b < 0 || b > a) return 0;
    res = 1;
    for (int j = 1; j <= b; j++) res = res * (a - b + j) / j;
    return res;
  endfunction

  function automatic int selWidth(input int n, input int k);
    int c;
    c = binom(n, k);
    return (c > 1) ? $clog2(c) : 1;
  endfunction

  function automatic int wordWidth(input int n, input int k, input int sw, input int ow);
    return selWidth(n, k) + (2 ** k) * sw + ow;
  endfunction

endpackage

// File: rtl/fsm_seq_ctrl.sv
module fsm_seq_ctrl
  import fsm_seq_pkg::*;
(
  input  logic       rst,
  input  logic       wrEn,
  output seqStrobe_t strb
);

  always_comb begin
    strb.clrState = rst;
    strb.loadEn   = rst & wrEn;
    strb.stepEn   = ~rst;
  end

endmodule

// File: rtl/fsm_seq_datapath.sv
module fsm_seq_datapath
  import fsm_seq_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int K_SEL   = 2,
  parameter int STATE_W = 3,
  parameter int OUT_W   = 4
) (
  input  logic                                              clk,
  input  seqStrobe_t                                        strb,
  input  logic [STATE_W-1:0]                                wrAddr,
  input  logic [wordWidth(N_IN,K_SEL,STATE_W,OUT_W)-1:0]    wrData,
  input  logic [N_IN-1:0]                                   inVec,
  output logic [STATE_W-1:0]                                stateQ,
  output logic [OUT_W-1:0]                                  outVec,
  output logic                                              selErr
);

  localparam int NUM_SUB   = binom(N_IN, K_SEL);
  localparam int SEL_W     = selWidth(N_IN, K_SEL);
  localparam int SUB_SLOTS = 2 ** SEL_W;
  localparam int NXT_CNT   = 2 ** K_SEL;
  localparam int WORD_W    = wordWidth(N_IN, K_SEL, STATE_W, OUT_W);
  localparam int DEPTH     = 2 ** STATE_W;
  localparam logic [SEL_W:0] NUM_SUB_V = (SEL_W+1)'(NUM_SUB);

  // Position of element 'slot' in the subset of lexicographic rank 'rank'
  function automatic int subsetPos(input int rank, input int slot);
    int rem, lo, pos, cnt;
    bit found;
    rem = rank; lo = 0; pos = 0;
    for (int i = 0; i < K_SEL; i++) begin
      found = 1'b0;
      for (int cand = 0; cand < N_IN; cand++) begin
        if (!found && cand >= lo) begin
          cnt = binom(N_IN - cand - 1, K_SEL - i - 1);
          if (rem < cnt) begin
            if (i == slot) pos = cand;
            lo = cand + 1;
            found = 1'b1;
          end else begin
            rem = rem - cnt;
          end
        end
      end
    end
    return pos;
  endfunction

  logic [WORD_W-1:0]  memQ [DEPTH];
  logic [WORD_W-1:0]  curWord;
  logic [SEL_W-1:0]   selIdx;
  logic [K_SEL-1:0]   subsetBits [SUB_SLOTS];
  logic [K_SEL-1:0]   testBits;
  logic [STATE_W-1:0] nxtField [NXT_CNT];
  logic [STATE_W-1:0] nextState;

  always_ff @(posedge clk) begin
    if (strb.loadEn) memQ[wrAddr] <= wrData;
  end

  assign curWord = memQ[stateQ];
  assign selIdx  = curWord[SEL_W-1:0];
  assign outVec  = curWord[WORD_W-1 -: OUT_W];

  for (genvar j = 0; j < NXT_CNT; j++) begin : g_nxt
    assign nxtField[j] = curWord[SEL_W + j*STATE_W +: STATE_W];
  end

  // Test-set multiplexer inputs: one k-bit group per legal subset
  for (genvar s = 0; s < SUB_SLOTS; s++) begin : g_sub
    if (s < NUM_SUB) begin : g_legal
      for (genvar b = 0; b < K_SEL; b++) begin : g_bit
        localparam int POS = subsetPos(s, b);
        assign subsetBits[s][b] = inVec[POS];
      end
    end else begin : g_pad
      assign subsetBits[s] = '0;
    end
  end

  assign selErr    = ({1'b0, selIdx} >= NUM_SUB_V);
  assign testBits  = subsetBits[selIdx];
  assign nextState = selErr ? nxtField[0] : nxtField[testBits];

  always_ff @(posedge clk) begin
    if (strb.clrState)    stateQ <= '0;
    else if (strb.stepEn) stateQ <= nextState;
  end

  // R1: reset lands on state zero
  p_reset_zero_r1: assert property (@(posedge clk) strb.clrState |=> stateQ == '0)
    else $error("R1 state not zero after reset");

  // R6: illegal index takes field 0
  p_illegal_field0_r6: assert property (@(posedge clk) disable iff (strb.clrState)
    (selErr && strb.stepEn) |=> stateQ == $past(nxtField[0]))
    else $error("R6 illegal index did not take field 0");

  // R7: loading never overlaps running
  p_load_halted_r7: assert property (@(posedge clk) strb.loadEn |-> !strb.stepEn)
    else $error("R7 load while running");

  // R5: with state and memory unchanged, output holds
  p_out_steady_r5: assert property (@(posedge clk) disable iff (strb.clrState)
    (!$past(strb.clrState) && $stable(stateQ)) |-> $stable(outVec))
    else $error("R5 output moved without state change");

endmodule

// File: rtl/fsm_seq_top.sv
module fsm_seq_top
  import fsm_seq_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int K_SEL   = 2,
  parameter int STATE_W = 3,
  parameter int OUT_W   = 4
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           wrEn,
  input  logic [STATE_W-1:0]                             wrAddr,
  input  logic [wordWidth(N_IN,K_SEL,STATE_W,OUT_W)-1:0] wrData,
  input  logic [N_IN-1:0]                                inVec,
  output logic [STATE_W-1:0]                             stateOut,
  output logic [OUT_W-1:0]                               outVec,
  output logic                                           selErr
);

  seqStrobe_t strb;

  fsm_seq_ctrl u_ctrl (
    .rst  (rst),
    .wrEn (wrEn),
    .strb (strb)
  );

  fsm_seq_datapath #(
    .N_IN(N_IN), .K_SEL(K_SEL), .STATE_W(STATE_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk    (clk),
    .strb   (strb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .inVec  (inVec),
    .stateQ (stateOut),
    .outVec (outVec),
    .selErr (selErr)
  );

endmodule

// File: tb/tb_fsm_seq_top.sv
`timescale 1ns/1ps
module tb_fsm_seq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [18:0] wrData = '0;
  logic [3:0]  inVec = '0;
  logic [2:0]  stateOut;
  logic [3:0]  outVec;
  logic        selErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fsm_seq_top dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .inVec(inVec), .stateOut(stateOut), .outVec(outVec), .selErr(selErr)
  );

  typedef struct packed { logic [3:0] inV; logic [2:0] nxt; } vec_t;
  // Word s: index s, field j = s+j+1, output s+5 (states 6,7 illegal index)
  localparam vec_t VEC [17] = '{
    '{4'b0010, 3'd3}, '{4'b0100, 3'd6}, '{4'b1111, 3'd7}, '{4'b0000, 3'd0},
    '{4'b0001, 3'd2}, '{4'b1000, 3'd5}, '{4'b0111, 3'd7}, '{4'b1010, 3'd0},
    '{4'b1100, 3'd1}, '{4'b0101, 3'd5}, '{4'b1100, 3'd1}, '{4'b0100, 3'd4},
    '{4'b1000, 3'd7}, '{4'b0000, 3'd0}, '{4'b0011, 3'd4}, '{4'b0010, 3'd6},
    '{4'b1111, 3'd7}
  };

  function automatic logic [18:0] mkWord(input int sel, input int f0, input int f1,
                                         input int f2, input int f3, input int o);
    return {4'(o), 3'(f3), 3'(f2), 3'(f1), 3'(f0), 3'(sel)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cur;
    tick(); tick();
    // Program all words in reset (R2 layout)
    for (int s = 0; s < 8; s++) begin
      wrEn = 1'b1; wrAddr = 3'(s);
      wrData = mkWord(s, (s+1)%8, (s+2)%8, (s+3)%8, (s+4)%8, (s+5)%16);
      tick();
    end
    wrEn = 1'b0;
    chk("R1 reset state", int'(stateOut), 0);
    rst = 1'b0;
    cur = 0;
    foreach (VEC[i]) begin
      chk("R5 output field", int'(outVec), (cur + 5) % 16);
      chk("R6 error flag", int'(selErr), (cur >= 6) ? 1 : 0);
      inVec = VEC[i].inV;
      tick();
      chk("R3/R4 next state", int'(stateOut), int'(VEC[i].nxt));
      cur = int'(VEC[i].nxt);
    end

    // R1: reset from a nonzero state
    rst = 1'b1; inVec = 4'b1111;
    tick();
    chk("R1 reset from state 7", int'(stateOut), 0);
    // Reload word 0 in reset: index 2 = {0,3}, fields 1..4, output 12
    wrEn = 1'b1; wrAddr = 3'd0; wrData = mkWord(2, 1, 2, 3, 4, 12);
    tick();
    wrEn = 1'b0; inVec = 4'b0110;
    tick();
    chk("R1 state held in reset", int'(stateOut), 0);
    rst = 1'b0;
    chk("R2 reloaded output field", int'(outVec), 12);
    chk("R6 legal index flag low", int'(selErr), 0);
    inVec = 4'b1001;
    tick();
    chk("R3 subset {0,3} select 3", int'(stateOut), 4);

    // R7: write out of reset must be ignored
    wrEn = 1'b1; wrAddr = 3'd4; wrData = mkWord(0, 0, 0, 0, 0, 0);
    inVec = 4'b1000;
    tick();
    wrEn = 1'b0;
    chk("R4 step during ignored write", int'(stateOut), 7);
    tick();
    chk("R6 illegal to field 0", int'(stateOut), 0);
    inVec = 4'b1001;
    tick();
    chk("R7 back at state 4", int'(stateOut), 4);
    chk("R7 word 4 output untouched", int'(outVec), 9);
    chk("R7 word 4 index untouched", int'(selErr), 0);
    inVec = 4'b1000;
    tick();
    chk("R7 word 4 fields untouched", int'(stateOut), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule